// File: doc/BRIEF.md
# Run-Time Partitioned Shared FIFO with Level Watermarks

This block holds one shared storage array of 512 words. Software divides it at run time into one, two, four or eight equal circular buffers. Several sample producers feed the block. Each producer carries a buffer-select value that names its target buffer. A fixed-priority arbiter accepts one producer word per cycle. A single consumer port pops words from a buffer it selects, and the data comes back one cycle later.

Each buffer has its own fill count and a programmable level threshold. When the count reaches a nonzero threshold, a sticky watermark flag is set. Two more sticky flags record a write dropped because the buffer was full and a read made while the buffer was empty. All three kinds of flag can be cleared per buffer by writing 1. Each buffer has an enable bit, and the enabled flags of all buffers are combined onto one dedicated interrupt output. Changing the split setting flushes every buffer.

Top module: `sfifo_split_top`

## Requirements
- R1: `split_mode` code 0, 1, 2 and 3 gives 1, 2, 4 and 8 buffers of 512, 256, 128 and 64 words. Buffer k uses words k×size to (k+1)×size−1, and its pointers wrap inside that range. A buffer that does not exist in the current mode always reports a count of zero.
- R2: Source i takes its buffer number from `src_sel[3i+2:3i]`. Only the low log2(number of buffers) bits are used, so the value is taken modulo the buffer count.
- R3: Each buffer returns words in the order they were written. A read requested in one cycle shows its word on `rd_data`, with `rd_valid` high, after the next clock edge.
- R4: A write to a full buffer is dropped, and that buffer's count does not change. The write sets bit k of `ovf_stat`.
- R5: A read from an empty buffer returns zero on `rd_data` and sets bit k of `udf_stat`.
- R6: Bit k of `wm_stat` is set at the clock edge after the count of buffer k is greater than or equal to a nonzero threshold `thresh[10k+9:10k]`. A threshold of zero never sets it.
- R7: All status bits are sticky. Writing 1 to the matching bit of `wm_clr`, `ovf_clr` or `udf_clr` clears it at the next edge. If the set condition holds in that same cycle, the set wins.
- R8: `fifo_irq` is high when some buffer k has `irq_en[k]` = 1 and any of its watermark, overflow or underflow bits set.
- R9: When several sources request in the same cycle, only the lowest-index requester gets `src_ready`, and it is written that cycle. The other requesters wait.
- R10: The cycle in which `split_mode` differs from the mode in use is a flush cycle. During it no source is ready and no read is done. After it, every count and status bit is zero.
- R11: While `rst_n` is low at a clock edge, all counts, status bits, `rd_valid` and `fifo_irq` go to zero.
- R12: `buf_count[10k+9:10k]` gives the number of words held in buffer k after the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| split_mode | input | 2 | Partition code: 0=1, 1=2, 2=4, 3=8 buffers |
| thresh | input | 80 | Per-buffer level threshold, 10 bits per buffer |
| irq_en | input | 8 | Per-buffer interrupt enable |
| src_valid | input | 4 | Per-source write request |
| src_sel | input | 12 | Per-source buffer select, 3 bits each |
| src_data | input | 64 | Per-source write word, 16 bits each |
| src_ready | output | 4 | Source is accepted this cycle |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Buffer to read |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 16 | Read word, zero on underflow |
| wm_clr | input | 8 | Write-1 clear of watermark flags |
| ovf_clr | input | 8 | Write-1 clear of overflow flags |
| udf_clr | input | 8 | Write-1 clear of underflow flags |
| wm_stat | output | 8 | Sticky watermark flags |
| ovf_stat | output | 8 | Sticky overflow flags |
| udf_stat | output | 8 | Sticky underflow flags |
| buf_count | output | 80 | Per-buffer fill count, 10 bits per buffer |
| fifo_irq | output | 1 | Combined FIFO interrupt |

## Verification
The main function is first tried with an interleaved stream of writes from all four sources into four buffers, mixed with reads. This shows that buffers keep their own ordering and do not leak into each other. A fill of one 64-word buffer to capacity and past it, then a full drain and a refill, checks the overflow drop, the pointer wrap inside that buffer's own range, and the end of the buffer. Simultaneous requests with a select larger than the buffer count separate priority order from select folding. The watermark series moves the count across the threshold while the enable is off and then on, and clears the flag both while the condition still holds and after it has gone. This tells a sticky, level-set flag apart from an edge-set one.

// File: rtl/sfifo_pkg.sv
// Package: shared types for the partitioned FIFO.
// Assumes at most four split settings (2-bit code).
package sfifo_pkg;

    // Split setting code; the value is log2 of the buffer count.
    typedef enum logic [1:0] {
        SPLIT_ONE   = 2'd0,
        SPLIT_TWO   = 2'd1,
        SPLIT_FOUR  = 2'd2,
        SPLIT_EIGHT = 2'd3
    } split_e;

    // Event flags of one buffer.
    typedef struct packed {
        logic wm;
        logic ovf;
        logic udf;
    } buf_evt_t;

endpackage

// File: rtl/sfifo_arb.sv
// Module: fixed-priority request arbiter.
// Grants the lowest-index active request, one grant per cycle.
// Assumes: purely combinational; clk/rst_n only time the assertions.
module sfifo_arb #(
    parameter  int unsigned NSRC = 4,
    localparam int unsigned SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [SW-1:0]   win
);

    // Scan from index 0 upward and keep the first requester.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        win   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                win      = SW'(i);
                found    = 1'b1;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                         // R9
    AST_GRANT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|(grant & req)));                             // R9

    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_prio
            AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
                grant[g] |-> !(|req[g-1:0]));                     // R9
        end
    endgenerate

endmodule

// File: rtl/sfifo_mem.sv
// Module: shared word store, one write port and one registered read port.
// Assumes: the controller never reads and writes the same word in one cycle.
module sfifo_mem #(
    parameter  int unsigned DEPTH = 512,
    parameter  int unsigned DW    = 16,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    // Store one accepted word.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Fetch the word for a hit read.
    always_ff @(posedge clk) begin
        if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/sfifo_ctrl.sv
// Module: per-buffer pointers, fill counts and sticky event flags.
// Maps a buffer number and an offset onto the shared array, using the split
// setting. Assumes: the buffer numbers given are already folded to the active
// count; flush zeroes all state.
module sfifo_ctrl #(
    parameter  int unsigned DEPTH = 512,
    parameter  int unsigned NBUF  = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1,
    localparam int unsigned BW    = $clog2(NBUF),
    localparam int unsigned SHW   = $clog2(AW + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [BW-1:0]      wr_buf,
    input  logic               rd_en,
    input  logic [BW-1:0]      rd_buf,
    input  logic [NBUF*CW-1:0] thresh,
    input  logic [NBUF-1:0]    wm_clr,
    input  logic [NBUF-1:0]    ovf_clr,
    input  logic [NBUF-1:0]    udf_clr,
    output logic               wr_do,
    output logic [AW-1:0]      wr_addr,
    output logic               rd_hit,
    output logic [AW-1:0]      rd_addr,
    output logic [NBUF*CW-1:0] count,
    output logic [NBUF-1:0]    wm_q,
    output logic [NBUF-1:0]    ovf_q,
    output logic [NBUF-1:0]    udf_q
);

    logic [AW-1:0]  wp  [NBUF];
    logic [AW-1:0]  rp  [NBUF];
    logic [CW-1:0]  cnt [NBUF];
    logic [CW-1:0]  thr [NBUF];
    logic [CW-1:0]  size;
    logic [SHW-1:0] shamt;
    logic [NBUF-1:0] push, pop, wm_set, ovf_set, udf_set;

    assign size  = CW'(DEPTH) >> mode;
    assign shamt = SHW'(AW) - SHW'(mode);

    generate
        for (genvar k = 0; k < NBUF; k++) begin : g_buf
            // Decode the requests and events of buffer k.
            assign thr[k]     = thresh[k*CW +: CW];
            assign push[k]    = wr_en && (wr_buf == BW'(k)) && (cnt[k] != size);
            assign ovf_set[k] = wr_en && (wr_buf == BW'(k)) && (cnt[k] == size);
            assign pop[k]     = rd_en && (rd_buf == BW'(k)) && (cnt[k] != '0);
            assign udf_set[k] = rd_en && (rd_buf == BW'(k)) && (cnt[k] == '0);
            assign wm_set[k]  = (thr[k] != '0) && (cnt[k] >= thr[k]);
            assign count[k*CW +: CW] = cnt[k];

            AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                cnt[k] <= size);                                                  // R4
            AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                (!flush && ovf_set[k] && !pop[k]) |=> ($stable(cnt[k]) && ovf_q[k])); // R4
            AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                (!flush && udf_set[k]) |=> udf_q[k]);                             // R5
            AST_WM_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
                (!flush && (thr[k] != '0) && (cnt[k] >= thr[k])) |=> wm_q[k]);    // R6
            AST_WM_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
                ((thr[k] == '0) && !wm_q[k]) |=> !wm_q[k]);                       // R6
            AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                flush |=> (cnt[k] == '0 && !wm_q[k] && !ovf_q[k] && !udf_q[k]));  // R10
            AST_IDLE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
                (CW'(k) >= (CW'(1) << mode)) |-> (cnt[k] == '0));                 // R1
        end
    endgenerate

    assign wr_do   = |push;
    assign rd_hit  = |pop;
    assign wr_addr = (AW'(wr_buf) << shamt) | wp[wr_buf];
    assign rd_addr = (AW'(rd_buf) << shamt) | rp[rd_buf];

    // Advance the pointers and counts; each pointer wraps at the buffer size.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int k = 0; k < NBUF; k++) begin
                wp[k]  <= '0;
                rp[k]  <= '0;
                cnt[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NBUF; k++) begin
                if (push[k]) wp[k] <= (CW'(wp[k]) == size - CW'(1)) ? '0 : wp[k] + AW'(1);
                if (pop[k])  rp[k] <= (CW'(rp[k]) == size - CW'(1)) ? '0 : rp[k] + AW'(1);
                cnt[k] <= cnt[k] + CW'(push[k]) - CW'(pop[k]);
            end
        end
    end

    // Sticky flags: a set wins over a clear written in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wm_q  <= '0;
            ovf_q <= '0;
            udf_q <= '0;
        end else begin
            wm_q  <= (wm_q  & ~wm_clr)  | wm_set;
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
            udf_q <= (udf_q & ~udf_clr) | udf_set;
        end
    end

endmodule

// File: rtl/sfifo_split_top.sv
// Module: partitioned shared FIFO top.
// Arbitrates producer writes, folds the buffer selects to the active count,
// drives the shared store, returns read data one cycle later and combines
// the enabled flags into one interrupt. Assumes NBUF is 8 or less (2-bit mode).
module sfifo_split_top
    import sfifo_pkg::*;
#(
    parameter  int unsigned DEPTH = 512,
    parameter  int unsigned NBUF  = 8,
    parameter  int unsigned NSRC  = 4,
    parameter  int unsigned DW    = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1,
    localparam int unsigned BW    = $clog2(NBUF),
    localparam int unsigned SW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         split_mode,
    input  logic [NBUF*CW-1:0] thresh,
    input  logic [NBUF-1:0]    irq_en,
    input  logic [NSRC-1:0]    src_valid,
    input  logic [NSRC*BW-1:0] src_sel,
    input  logic [NSRC*DW-1:0] src_data,
    output logic [NSRC-1:0]    src_ready,
    input  logic               rd_en,
    input  logic [BW-1:0]      rd_sel,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    input  logic [NBUF-1:0]    wm_clr,
    input  logic [NBUF-1:0]    ovf_clr,
    input  logic [NBUF-1:0]    udf_clr,
    output logic [NBUF-1:0]    wm_stat,
    output logic [NBUF-1:0]    ovf_stat,
    output logic [NBUF-1:0]    udf_stat,
    output logic [NBUF*CW-1:0] buf_count,
    output logic               fifo_irq
);

    split_e          mode_q;
    logic            flush;
    logic [BW-1:0]   sel_mask;
    logic [NSRC-1:0] grant;
    logic [SW-1:0]   win;
    logic            wr_do, rd_hit, rd_fire, rd_hit_q;
    logic [AW-1:0]   wr_addr, rd_addr;
    logic [BW-1:0]   wr_buf, rd_buf;
    logic [DW-1:0]   mem_q;
    buf_evt_t [NBUF-1:0] evt;

    // Track the split setting in use; a difference triggers one flush cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= SPLIT_ONE;
        else        mode_q <= split_e'(split_mode);
    end

    assign flush    = (split_mode != mode_q);
    assign sel_mask = ~({BW{1'b1}} << mode_q);

    sfifo_arb #(.NSRC(NSRC)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (flush ? '0 : src_valid),
        .grant (grant),
        .win   (win)
    );

    assign src_ready = grant;
    assign wr_buf    = src_sel[win*BW +: BW] & sel_mask;
    assign rd_fire   = rd_en && !flush;
    assign rd_buf    = rd_sel & sel_mask;

    sfifo_ctrl #(.DEPTH(DEPTH), .NBUF(NBUF)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .flush   (flush),
        .wr_en   (|grant),
        .wr_buf  (wr_buf),
        .rd_en   (rd_fire),
        .rd_buf  (rd_buf),
        .thresh  (thresh),
        .wm_clr  (wm_clr),
        .ovf_clr (ovf_clr),
        .udf_clr (udf_clr),
        .wr_do   (wr_do),
        .wr_addr (wr_addr),
        .rd_hit  (rd_hit),
        .rd_addr (rd_addr),
        .count   (buf_count),
        .wm_q    (wm_stat),
        .ovf_q   (ovf_stat),
        .udf_q   (udf_stat)
    );

    sfifo_mem #(.DEPTH(DEPTH), .DW(DW)) mem_i (
        .clk   (clk),
        .we    (wr_do),
        .waddr (wr_addr),
        .wdata (src_data[win*DW +: DW]),
        .re    (rd_hit),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    // Register whether a read was issued and whether it found data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_hit_q <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            rd_hit_q <= rd_hit;
        end
    end

    assign rd_data = rd_hit_q ? mem_q : '0;

    // Gather each buffer's flags and merge the enabled ones.
    always_comb begin
        fifo_irq = 1'b0;
        for (int k = 0; k < NBUF; k++) begin
            evt[k] = '{wm: wm_stat[k], ovf: ovf_stat[k], udf: udf_stat[k]};
            fifo_irq = fifo_irq | (irq_en[k] & (|evt[k]));
        end
    end

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rd_valid);                                    // R3
    AST_FLUSH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (src_ready == '0));                             // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_irq |-> (|(irq_en & (wm_stat | ovf_stat | udf_stat)))); // R8

endmodule

// File: tb/sfifo_split_top_tb_top.sv
`timescale 1ns/1ps
module sfifo_split_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  split_mode;
    logic [79:0] thresh;
    logic [7:0]  irq_en, wm_clr, ovf_clr, udf_clr;
    logic [3:0]  src_valid;
    logic [11:0] src_sel;
    logic [63:0] src_data;
    logic [3:0]  src_ready;
    logic        rd_en, rd_valid, fifo_irq;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic [7:0]  wm_stat, ovf_stat, udf_stat;
    logic [79:0] buf_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sfifo_split_top dut_i (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .thresh(thresh),
        .irq_en(irq_en), .src_valid(src_valid), .src_sel(src_sel),
        .src_data(src_data), .src_ready(src_ready), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
        .wm_clr(wm_clr), .ovf_clr(ovf_clr), .udf_clr(udf_clr),
        .wm_stat(wm_stat), .ovf_stat(ovf_stat), .udf_stat(udf_stat),
        .buf_count(buf_count), .fifo_irq(fifo_irq)
    );

    // Vector: [21] 1=write/0=read, [20:19] source, [18:16] buffer, [15:0] data or expected.
    localparam logic [21:0] VEC [12] = '{
        {1'b1, 2'd0, 3'd0, 16'h1111}, {1'b1, 2'd1, 3'd1, 16'h2222},
        {1'b1, 2'd2, 3'd0, 16'h3333}, {1'b1, 2'd3, 3'd2, 16'h4444},
        {1'b0, 2'd0, 3'd0, 16'h1111}, {1'b1, 2'd0, 3'd3, 16'h5555},
        {1'b0, 2'd0, 3'd1, 16'h2222}, {1'b0, 2'd0, 3'd0, 16'h3333},
        {1'b0, 2'd0, 3'd3, 16'h5555}, {1'b0, 2'd0, 3'd2, 16'h4444},
        {1'b1, 2'd1, 3'd1, 16'h6666}, {1'b0, 2'd0, 3'd1, 16'h6666}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] cnt_of(input int b);
        return buf_count[b*10 +: 10];
    endfunction

    task automatic push(input int src, input logic [2:0] b, input logic [15:0] d);
        @(negedge clk);
        src_valid[src] = 1'b1;
        src_sel[src*3 +: 3] = b;
        src_data[src*16 +: 16] = d;
        @(negedge clk);
        src_valid[src] = 1'b0;
    endtask

    task automatic pop(input logic [2:0] b, output logic [15:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_sel = b;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        split_mode = m;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic v;
        rst_n = 1'b0; split_mode = 2'd0; thresh = '0; irq_en = '0;
        wm_clr = '0; ovf_clr = '0; udf_clr = '0; src_valid = '0;
        src_sel = '0; src_data = '0; rd_en = 1'b0; rd_sel = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(buf_count == '0 && wm_stat == '0 && ovf_stat == '0 && udf_stat == '0,
            "R11 counts/status", {16'h0, wm_stat, ovf_stat}, 32'h0);
        chk(!rd_valid && !fifo_irq, "R11 rd_valid/irq", {rd_valid, fifo_irq}, 0);
        rst_n = 1'b1;

        // R3/R1: interleaved traffic over four buffers, checked by table
        set_mode(2'd2);
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][21]) begin
                push(int'(VEC[i][20:19]), VEC[i][18:16], VEC[i][15:0]);
            end else begin
                pop(VEC[i][18:16], d, v);
                chk(d == VEC[i][15:0] && v, "R3 order per buffer", d, VEC[i][15:0]);
            end
        end

        // R9/R2: simultaneous sources 0 and 2; select 3 folds to buffer 1 in two-buffer mode
        set_mode(2'd1);
        @(negedge clk);
        src_sel = {3'd0, 3'd3, 3'd0, 3'd0};
        src_data = {16'h0, 16'hC2C2, 16'h0, 16'hC0C0};
        src_valid = 4'b0101;
        #1 chk(src_ready == 4'b0001, "R9 lowest index first", src_ready, 4'b0001);
        @(negedge clk);
        src_valid[0] = 1'b0;
        #1 chk(src_ready == 4'b0100, "R9 waiting source next", src_ready, 4'b0100);
        @(negedge clk);
        src_valid = '0;
        chk(cnt_of(0) == 10'd1 && cnt_of(1) == 10'd1, "R2 select folding / R12 count",
            {cnt_of(0), cnt_of(1)}, {10'd1, 10'd1});
        pop(3'd1, d, v);
        chk(d == 16'hC2C2, "R2 folded select data", d, 16'hC2C2);

        // R4/R1: fill a 64-word buffer, overflow, drain, wrap
        set_mode(2'd3);
        for (int i = 0; i < 64; i++) push(i % 4, 3'd5, 16'(i));
        chk(cnt_of(5) == 10'd64, "R12 full count", cnt_of(5), 64);
        chk(ovf_stat == '0, "R4 no early overflow", ovf_stat, 0);
        push(0, 3'd5, 16'hBEEF);
        chk(ovf_stat == 8'h20 && cnt_of(5) == 10'd64, "R4 drop on full",
            {ovf_stat, cnt_of(5)}, {8'h20, 10'd64});
        pop(3'd5, d, v);
        chk(d == 16'd0, "R3 first word after fill", d, 0);
        for (int i = 1; i < 63; i++) pop(3'd5, d, v);
        pop(3'd5, d, v);
        chk(d == 16'd63, "R4 last word kept, extra dropped", d, 63);
        push(1, 3'd5, 16'hAAAA);
        pop(3'd5, d, v);
        chk(d == 16'hAAAA && cnt_of(5) == 10'd0, "R1 wrap inside buffer", d, 16'hAAAA);
        chk(cnt_of(4) == 0 && cnt_of(6) == 0, "R1 neighbours untouched",
            {cnt_of(4), cnt_of(6)}, 0);

        // R5: empty read
        pop(3'd5, d, v);
        chk(d == 16'h0 && v && udf_stat == 8'h20, "R5 empty read", {d, udf_stat}, {16'h0, 8'h20});

        // R7: clear overflow and underflow by write-1
        @(negedge clk);
        ovf_clr = 8'h20; udf_clr = 8'h20;
        @(negedge clk);
        ovf_clr = '0; udf_clr = '0;
        chk(ovf_stat == 0 && udf_stat == 0, "R7 write-1 clear", {ovf_stat, udf_stat}, 0);

        // R6/R8: watermarks in four-buffer mode
        set_mode(2'd2);
        thresh[1*10 +: 10] = 10'd3;
        thresh[2*10 +: 10] = 10'd0;
        irq_en = 8'b0000_0100;
        push(0, 3'd1, 16'h1);
        push(0, 3'd1, 16'h2);
        @(negedge clk);
        chk(wm_stat[1] == 1'b0, "R6 below threshold", wm_stat, 0);
        push(0, 3'd1, 16'h3);
        @(negedge clk);
        chk(wm_stat[1] == 1'b1, "R6 threshold reached", wm_stat, 8'h02);
        chk(fifo_irq == 1'b0, "R8 disabled buffer silent", fifo_irq, 0);
        for (int i = 0; i < 5; i++) push(1, 3'd2, 16'(i));
        @(negedge clk);
        chk(wm_stat[2] == 1'b0, "R6 zero threshold never", wm_stat, 8'h02);
        irq_en = 8'b0000_0110;
        #1 chk(fifo_irq == 1'b1, "R8 enabled flag raises irq", fifo_irq, 1);
        @(negedge clk);
        wm_clr = 8'h02;
        @(negedge clk);
        wm_clr = '0;
        chk(wm_stat[1] == 1'b1, "R7 set wins over clear", wm_stat, 8'h02);
        pop(3'd1, d, v);
        @(negedge clk);
        wm_clr = 8'h02;
        @(negedge clk);
        wm_clr = '0;
        chk(wm_stat[1] == 1'b0 && !fifo_irq, "R7 clear after level drop",
            {wm_stat, fifo_irq}, 0);

        // R10: mode change flushes; no grant in the flush cycle
        push(2, 3'd3, 16'h7777);
        @(negedge clk);
        split_mode = 2'd0;
        src_valid[0] = 1'b1;
        src_sel[2:0] = 3'd0;
        #1 chk(src_ready == 4'b0000, "R10 no grant while flushing", src_ready, 0);
        @(negedge clk);
        src_valid = '0;
        chk(buf_count == '0 && wm_stat == 0 && ovf_stat == 0 && udf_stat == 0,
            "R10 all state cleared", {buf_count[39:0]}, 0);

        // R1: single-buffer mode holds words beyond a smaller split size
        for (int i = 0; i < 70; i++) push(3, 3'd6, 16'(i + 100));
        chk(cnt_of(0) == 10'd70 && ovf_stat == 0, "R1 512-word buffer", cnt_of(0), 70);

        summary();
        $finish;
    end

endmodule